// File: doc/BRIEF.md
# PWM Time Base with Event Actions

A dual-output pulse-width modulation generator. The input clock passes through two cascaded prescaler stages to produce a time-base tick. On each tick a 16-bit counter advances from zero up to a programmed period and then wraps. The two outputs do not use a plain threshold test. Each output keeps a register that is changed by events, and each event has its own set, clear or toggle action. The counter reaching zero is one event. The counter matching that output's compare value is the other.

Software sets up the block through a synchronous write port: an enable strobe, a 3-bit address and 16 bits of data. Through this port it selects the two prescaler ratios, runs or freezes the counter, and sets the period, both compare values and the actions of each output. It can also load the counter directly. The period takes effect without shadowing, so a new value applies on the next tick.

Top module: `pwm_aq_timebase`

## Requirements
- R1: Control register (address 0) bits [2:0] select the first prescaler ratio of 2 raised to the code (1 to 128).
- R2: Control bits [5:3] select the second prescaler ratio: code 0 gives 1, codes 1 to 7 give twice the code (2 to 14).
- R3: With the counter running, it advances once every (first ratio × second ratio) clock cycles, up to 1792 cycles at the largest selects.
- R4: While running, the counter goes from 0 up to the period (address 1) and wraps to 0 on the tick after it reaches or exceeds the period, so one PWM cycle lasts period+1 ticks. This holds up to a period of 65535.
- R5: Control bit 6 set to 0 freezes the counter. In freeze the counter value and both outputs hold.
- R6: Action registers at address 4 (output A) and address 5 (output B) hold the zero-event action in bits [1:0] and the compare-event action in bits [3:2]. The encodings are 00 none, 01 drive low, 10 drive high, 11 toggle. A zero event is a running tick on which the counter is 0.
- R7: A compare event for output A is a running tick on which the counter equals compare A (address 2). For output B the counter must equal compare B (address 3).
- R8: When a zero event and a compare event fall on the same tick, a compare action other than none wins over the zero action.
- R9: A period write changes the wrap point from the very next tick.
- R10: A write to address 6 loads the counter at any time and overrides that cycle's tick. That cycle produces no output event.
- R11: Any control write restarts the prescaler, so the first tick comes one full new ratio after the write.
- R12: After reset the counter is 0, both outputs are low, the block is frozen and all selects and registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| count_o | output | 16 | Current time-base counter value |

## Verification
A prescaler phase that is off by even one cycle moves every counter step. It shows on count_o at the first tick after a control write, and the bench catches it by counting cycles to that first change. A wrong counter or event decision appears at most one period later as an output edge on the wrong tick. A bench model that runs in step with the block compares both outputs and the count on every cycle. Freeze and counter loads are checked at the ports on the cycle right after the write.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACTA  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTB  = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned SELW = 3,
  parameter int unsigned NCH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [SELW-1:0]   sel1_o,
  output logic [SELW-1:0]   sel2_o,
  output logic              run_o,
  output logic [DW-1:0]     period_o,
  output logic [DW-1:0]     cmp_o      [NCH],
  output act_e              act_zero_o [NCH],
  output act_e              act_cmp_o  [NCH],
  output logic              sel_wr_o,
  output logic              cnt_wr_o,
  output logic [DW-1:0]     cnt_wdata_o
);
  localparam int unsigned RUN_BIT = 2 * SELW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel1_o   <= '0;
      sel2_o   <= '0;
      run_o    <= 1'b0;
      period_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) begin
        sel1_o <= wr_data_i[SELW-1:0];
        sel2_o <= wr_data_i[2*SELW-1:SELW];
        run_o  <= wr_data_i[RUN_BIT];
      end
      if (wr_addr_i == A_PER) period_o <= wr_data_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ADDR_W-1:0] cmp_addr, act_addr;
    assign cmp_addr = A_CMPA + ADDR_W'(c);
    assign act_addr = A_ACTA + ADDR_W'(c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_o[c]      <= '0;
        act_zero_o[c] <= ACT_NONE;
        act_cmp_o[c]  <= ACT_NONE;
      end else if (wr_en_i) begin
        if (wr_addr_i == cmp_addr) cmp_o[c] <= wr_data_i;
        if (wr_addr_i == act_addr) begin
          act_zero_o[c] <= act_e'(wr_data_i[1:0]);
          act_cmp_o[c]  <= act_e'(wr_data_i[3:2]);
        end
      end
    end
  end

  assign sel_wr_o    = wr_en_i && (wr_addr_i == A_CTRL);
  assign cnt_wr_o    = wr_en_i && (wr_addr_i == A_COUNT);
  assign cnt_wdata_o = wr_data_i;
endmodule

// File: rtl/pwm_aq_prescaler.sv
module pwm_aq_prescaler #(
  parameter int unsigned SELW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SELW-1:0] sel1_i,
  input  logic [SELW-1:0] sel2_i,
  input  logic            restart_i,
  output logic            tick_o
);
  localparam int unsigned MAXCODE = (1 << SELW) - 1;
  localparam int unsigned S1W     = (MAXCODE < 1) ? 1 : MAXCODE;
  localparam int unsigned S2W     = $clog2(2 * MAXCODE + 1);

  logic [S1W:0]   ratio1;
  logic [S2W-1:0] ratio2;
  logic [S1W-1:0] cnt1_q;
  logic [S2W-1:0] cnt2_q;
  logic           s1_pulse;
  logic           s2_last;

  assign ratio1   = (S1W+1)'(1) << sel1_i;
  assign ratio2   = (sel2_i == '0) ? S2W'(1) : S2W'({sel2_i, 1'b0});
  assign s1_pulse = ({1'b0, cnt1_q} == ratio1 - 1'b1);
  assign s2_last  = (cnt2_q == ratio2 - 1'b1);
  assign tick_o   = s1_pulse && s2_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else if (restart_i) begin
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else if (s1_pulse) begin
      cnt1_q <= '0;
      cnt2_q <= s2_last ? '0 : cnt2_q + 1'b1;
    end else begin
      cnt1_q <= cnt1_q + 1'b1;
    end
  end

  // R11: after a restart, the next cycle ticks only for a total ratio of 1
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tick_o == (sel1_i == '0 && sel2_i == '0)));

  // R3: ratios above 1 never tick on two cycles in a row
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && !(sel1_i == '0 && sel2_i == '0)) |=> !tick_o);
endmodule

// File: rtl/pwm_aq_counter.sv
module pwm_aq_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [DW-1:0] period_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic          ev_en_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_wr_i)          cnt_q <= cnt_wdata_i;
    else if (tick_i && run_i)   cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign ev_en_o = tick_i && run_i && !cnt_wr_i;

  // R5: a frozen counter holds unless software loads it
  p_freeze_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));

  // R4: without a load the counter holds, steps by one or wraps to zero
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  // R10: a load lands on the next cycle
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_q == $past(cnt_wdata_i)));
endmodule

// File: rtl/pwm_aq_action.sv
module pwm_aq_action
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_en_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] cmp_i,
  input  act_e          act_zero_i,
  input  act_e          act_cmp_i,
  output logic          out_o
);
  logic out_q;
  logic hit_zero, hit_cmp;
  act_e act_sel;

  assign hit_zero = ev_en_i && (cnt_i == '0);
  assign hit_cmp  = ev_en_i && (cnt_i == cmp_i);

  always_comb begin
    if (hit_cmp && act_cmp_i != ACT_NONE) act_sel = act_cmp_i;
    else if (hit_zero)                    act_sel = act_zero_i;
    else                                  act_sel = ACT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else begin
      unique case (act_sel)
        ACT_CLR: out_q <= 1'b0;
        ACT_SET: out_q <= 1'b1;
        ACT_TGL: out_q <= ~out_q;
        default: out_q <= out_q;
      endcase
    end
  end

  assign out_o = out_q;

  // R6: outside events the output holds
  p_quiet_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_en_i |=> $stable(out_q));

  // R8: compare set beats any zero action on the same tick
  p_cmp_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_en_i && cnt_i == '0 && cmp_i == '0 && act_cmp_i == ACT_SET) |=> out_q);
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned SELW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [DW-1:0]     count_o
);
  localparam int unsigned NCH = 2;

  logic [SELW-1:0] sel1, sel2;
  logic            run, sel_wr, cnt_wr, tick, ev_en;
  logic [DW-1:0]   period, cnt_wdata, cnt;
  logic [DW-1:0]   cmp      [NCH];
  act_e            act_zero [NCH];
  act_e            act_cmp  [NCH];
  logic [NCH-1:0]  outs;

  pwm_aq_regs #(.DW(DW), .SELW(SELW), .NCH(NCH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sel1_o(sel1), .sel2_o(sel2), .run_o(run), .period_o(period),
    .cmp_o(cmp), .act_zero_o(act_zero), .act_cmp_o(act_cmp),
    .sel_wr_o(sel_wr), .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata)
  );

  pwm_aq_prescaler #(.SELW(SELW)) u_presc (
    .clk_i, .rst_ni, .sel1_i(sel1), .sel2_i(sel2),
    .restart_i(sel_wr), .tick_o(tick)
  );

  pwm_aq_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .run_i(run), .period_i(period),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_o(cnt), .ev_en_o(ev_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    pwm_aq_action #(.DW(DW)) u_act (
      .clk_i, .rst_ni, .ev_en_i(ev_en), .cnt_i(cnt), .cmp_i(cmp[c]),
      .act_zero_i(act_zero[c]), .act_cmp_i(act_cmp[c]), .out_o(outs[c])
    );
  end

  assign pwm_a_o = outs[0];
  assign pwm_b_o = outs[1];
  assign count_o = cnt;
endmodule

// File: tb/tb_pwm_aq_timebase.sv
module tb_pwm_aq_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;
  logic [15:0] count;

  int n_checks = 0, n_fail = 0, mism = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_aq_timebase dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .count_o(count)
  );

  // reference model built from the requirements
  logic [2:0]  m_s1, m_s2;
  logic        m_run, m_a, m_b;
  logic [15:0] m_per, m_ca, m_cb, m_cnt;
  logic [3:0]  m_aa, m_ab;
  int          m_phase;

  function automatic int ratio(input logic [2:0] s1, input logic [2:0] s2);
    return (1 << s1) * ((s2 == 0) ? 1 : 2 * int'(s2));
  endfunction

  function automatic logic next_out(input logic o, input logic [3:0] act,
                                    input logic zero, input logic hit);
    logic [1:0] a;
    if (hit && act[3:2] != 2'b00) a = act[3:2];
    else if (zero)                a = act[1:0];
    else                          a = 2'b00;
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~o;
      default: return o;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_per <= 0; m_ca <= 0; m_cb <= 0;
      m_aa <= 0; m_ab <= 0; m_cnt <= 0; m_a <= 0; m_b <= 0; m_phase <= 0;
    end else begin
      automatic bit tk  = (m_phase == ratio(m_s1, m_s2) - 1);
      automatic bit cw  = wr_en && wr_addr == 3'd6;
      automatic bit ctl = wr_en && wr_addr == 3'd0;
      automatic bit ev  = tk && m_run && !cw;
      m_phase <= (ctl || tk) ? 0 : m_phase + 1;
      if (cw) m_cnt <= wr_data;
      else if (tk && m_run) m_cnt <= (m_cnt >= m_per) ? 16'd0 : m_cnt + 16'd1;
      if (ev) begin
        m_a <= next_out(m_a, m_aa, m_cnt == 0, m_cnt == m_ca);
        m_b <= next_out(m_b, m_ab, m_cnt == 0, m_cnt == m_cb);
      end
      if (wr_en) case (wr_addr)
        3'd0: begin m_s1 <= wr_data[2:0]; m_s2 <= wr_data[5:3]; m_run <= wr_data[6]; end
        3'd1: m_per <= wr_data;
        3'd2: m_ca  <= wr_data;
        3'd3: m_cb  <= wr_data;
        3'd4: m_aa  <= wr_data[3:0];
        3'd5: m_ab  <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  always @(negedge clk)
    if (rst_n && (pwm_a !== m_a || pwm_b !== m_b || count !== m_cnt)) mism++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input bit run, input logic [2:0] s1, input logic [2:0] s2);
    return {9'd0, run, s2, s1};
  endfunction

  // cycles from a run-starting control write to the first counter step
  task automatic measure(output int n);
    logic [15:0] c0;
    c0 = count;
    n = 0;
    do begin @(negedge clk); n++; end while (count == c0 && n < 4000);
    n = n - 1;
  endtask

  typedef struct packed {
    logic [2:0]  s1, s2;
    logic [15:0] per, ca, cb;
    logic [3:0]  aa, ab;
    logic [15:0] cyc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 3'd0, 16'd9, 16'd3, 16'd7, 4'b0110, 4'b0110, 16'd60},
    '{3'd1, 3'd0, 16'd5, 16'd2, 16'd4, 4'b1100, 4'b0110, 16'd80},
    '{3'd0, 3'd1, 16'd4, 16'd0, 16'd9, 4'b1001, 4'b0011, 16'd60},
    '{3'd2, 3'd3, 16'd3, 16'd1, 16'd2, 4'b0110, 4'b1001, 16'd300},
    '{3'd0, 3'd7, 16'd2, 16'd2, 16'd1, 4'b1110, 4'b0111, 16'd200},
    '{3'd0, 3'd0, 16'd0, 16'd0, 16'd0, 4'b1100, 4'b0011, 16'd20}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n, m0, edges_a;
    logic [15:0] c0;
    logic a0, b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(count == 0, "R12", "count after reset", count, 0);
    check(pwm_a == 0 && pwm_b == 0, "R12", "outputs after reset", {pwm_a, pwm_b}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(count == 0, "R12", "frozen count after release", count, 0);

    // table walk: R6 R7 R8 event actions against model
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      wr(3'd0, ctrl(0, v.s1, v.s2));
      wr(3'd1, v.per); wr(3'd2, v.ca); wr(3'd3, v.cb);
      wr(3'd4, {12'd0, v.aa}); wr(3'd5, {12'd0, v.ab});
      wr(3'd6, 16'd0);
      m0 = mism; edges_a = 0; a0 = pwm_a;
      wr(3'd0, ctrl(1, v.s1, v.s2));
      repeat (int'(v.cyc)) begin
        @(negedge clk);
        if (pwm_a != a0) edges_a++;
        a0 = pwm_a;
      end
      check(mism == m0, "R6/R7", $sformatf("vector %0d output mismatches", i), mism - m0, 0);
      check(edges_a > 0, "R7", $sformatf("vector %0d output A activity", i), edges_a, 1);
    end

    // R8: compare set with zero clear at count 0 (vector 2) leaves A high
    wr(3'd0, ctrl(0, 0, 0));
    wr(3'd1, 16'd4); wr(3'd2, 16'd0); wr(3'd4, 16'b1001);
    wr(3'd6, 16'd0);
    wr(3'd0, ctrl(1, 0, 0));
    repeat (12) @(negedge clk);
    check(pwm_a == 1'b1, "R8", "compare beats zero", pwm_a, 1);

    // R1 / R2 / R3 tick spacing
    wr(3'd0, ctrl(0, 3'd3, 3'd0)); wr(3'd1, 16'd1000); wr(3'd6, 16'd0);
    wr(3'd0, ctrl(1, 3'd3, 3'd0)); measure(n);
    check(n == 8, "R1", "first stage code 3 spacing", n, 8);
    wr(3'd0, ctrl(0, 3'd0, 3'd5)); wr(3'd6, 16'd0);
    wr(3'd0, ctrl(1, 3'd0, 3'd5)); measure(n);
    check(n == 10, "R2", "second stage code 5 spacing", n, 10);
    wr(3'd0, ctrl(0, 3'd7, 3'd7)); wr(3'd6, 16'd0);
    wr(3'd0, ctrl(1, 3'd7, 3'd7)); measure(n);
    check(n == 1792, "R3", "largest division spacing", n, 1792);

    // R11: rewrite control mid-phase restarts the prescaler
    wr(3'd0, ctrl(0, 3'd3, 3'd0)); wr(3'd6, 16'd0);
    wr(3'd0, ctrl(1, 3'd3, 3'd0));
    repeat (4) @(negedge clk);
    wr(3'd0, ctrl(1, 3'd3, 3'd0)); measure(n);
    check(n == 8, "R11", "restart on control write", n, 8);

    // R5: freeze holds count and outputs
    wr(3'd0, ctrl(1, 0, 0));
    repeat (7) @(negedge clk);
    wr(3'd0, ctrl(0, 0, 0));
    @(negedge clk);
    c0 = count; a0 = pwm_a; b0 = pwm_b;
    repeat (50) @(negedge clk);
    check(count == c0, "R5", "frozen count", count, c0);
    check(pwm_a == a0 && pwm_b == b0, "R5", "frozen outputs", {pwm_a, pwm_b}, {a0, b0});

    // R10: counter load while running
    wr(3'd1, 16'd1000);
    wr(3'd0, ctrl(1, 0, 0));
    wr(3'd6, 16'd500);
    @(negedge clk);
    check(count == 500, "R10", "load value", count, 500);
    @(negedge clk);
    check(count == 501, "R10", "step after load", count, 501);

    // R9: shorter period applies on next tick
    wr(3'd1, 16'd3);
    @(negedge clk);
    @(negedge clk);
    check(count == 0, "R9", "wrap after period write", count, 0);

    // R4: full-width wrap
    wr(3'd1, 16'd65535);
    wr(3'd6, 16'd65534);
    @(negedge clk);
    check(count == 16'd65534, "R4", "near top", count, 65534);
    @(negedge clk);
    check(count == 16'd65535, "R4", "at period", count, 65535);
    @(negedge clk);
    check(count == 0, "R4", "wrap to zero", count, 0);

    check(mism == 0, "R6", "model agreement over whole run", mism, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule